// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between three asynchronous external interrupt pins and a parent interrupt controller that only accepts active-high levels and rising edges. Each pin is brought into the clock domain by a two-flop synchronizer and then inverted if needed, so that an active-low or falling-edge source looks to the parent like an active-high or rising-edge one. Each line drives its own request output toward the parent.

A line set to an edge sense latches a pending flag when its normalized input rises. The flag stays set until software writes a one to it, and while it is set the line requests service. A line set to a level sense follows its synchronized input directly and latches nothing. Each line has an enable bit that masks its request. A clock-select bit is stored and read back only.

The three 8-bit line controls share one 32-bit register, read and written through a plain write-strobe and read-data port. A write replaces the configuration of all three lines at once, so software changes one line by reading the register, modifying the value and writing it back.

Top module: `extirq_cond`

## Requirements
- R1: After reset every control field reads zero, the register reads 0x00000000 and all three request outputs are low; each line i drives only req_o[i].
- R2: Line 0's field is register bits 23:16, line 1's is bits 15:8 and line 2's is bits 7:0. Within a field, bit 0 is pending, bit 4 is clock select, bit 5 is enable and bits 7:6 are the trigger type. Register bits 31:24 and field bits 3:1 read as zero.
- R3: Trigger type 00 is level high and 01 is level low. An enabled level-low line requests while its pin is low and not while it is high.
- R4: Trigger type 10 is rising edge and 11 is falling edge. A falling pin transition in type 11, or a rising one in type 10, sets pending. The opposite transition does not. Pending then stays set after the pin returns, and an edge line's request equals pending AND enable.
- R5: In a level type the pending bit never latches and reads zero; the request is the normalized input AND enable.
- R6: Writing a one to a line's pending bit clears it in the next cycle; writing a zero leaves it unchanged.
- R7: When an edge is detected in the same cycle as a clearing write, pending stays set.
- R8: With enable at zero the line's request is low, but an edge line still latches pending; setting enable again raises the request.
- R9: The clock-select bit is stored and read back and has no effect on any request.
- R10: An enabled level-high line's request rises on the second rising clock edge after its pin rises and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register contents |
| pin_i | input | 3 | Asynchronous external interrupt pins, bit i is line i |
| req_o | output | 3 | Normalized active-high requests to the parent, bit i is line i |

## Verification
Edge detection and a software clear can both act on the same pending flag in one cycle, and the edge must win. The bench provokes this by timing the pin change so that the synchronized edge is seen on the same clock edge that captures a write with the pending bit set. It then judges the outcome from the pending bit read back and from the request output. A clear with no edge present, and a write of zero to pending, are checked separately so that clear-wins and clear-ignored faults also show up.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
    localparam int unsigned NUM_LINES = 3;
    localparam int unsigned FIELD_W   = 8;
    localparam int unsigned REG_W     = 32;

    localparam int unsigned BIT_PEND = 0;
    localparam int unsigned BIT_CSEL = 4;
    localparam int unsigned BIT_EN   = 5;
    localparam int unsigned BIT_TRIG = 6;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'b00,
        TRIG_LVL_LO = 2'b01,
        TRIG_RISE   = 2'b10,
        TRIG_FALL   = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e trig;
        logic  en;
        logic  csel;
    } line_cfg_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } line_st_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d    = stg_q;
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      sync_i,
    input  line_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      pend_o,
    output logic      req_o
);
    line_st_t st_d, st_q;
    logic     invert, edge_mode, norm_now, norm_prev, edge_seen;

    always_comb begin
        invert    = cfg_i.trig[0];
        edge_mode = cfg_i.trig[1];
        norm_now  = sync_i ^ invert;
        norm_prev = st_q.prev ^ invert;
        edge_seen = norm_now & ~norm_prev;

        st_d      = st_q;
        st_d.prev = sync_i;
        if (!edge_mode)     st_d.pend = 1'b0;
        else if (edge_seen) st_d.pend = 1'b1;
        else if (clr_i)     st_d.pend = 1'b0;

        req_o  = cfg_i.en & (edge_mode ? st_q.pend : norm_now);
        pend_o = st_q.pend;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode && edge_seen) |=> st_q.pend); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode && clr_i && !edge_seen) |=> !st_q.pend); // R6
    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode && st_q.pend && !clr_i) |=> st_q.pend); // R4
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!edge_mode) |=> !st_q.pend); // R5
endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
    import extirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [REG_W-1:0]     wr_data_i,
    output logic [REG_W-1:0]     rd_data_o,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] req_o
);
    line_cfg_t [NUM_LINES-1:0] cfg_d, cfg_q;
    logic      [NUM_LINES-1:0] clr, pend, pin_sync;
    logic                      wr_data_unused;

    assign wr_data_unused = ^wr_data_i;

    extirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    always_comb begin
        cfg_d     = cfg_q;
        clr       = '0;
        rd_data_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            int unsigned base;
            base = (NUM_LINES - 1 - i) * FIELD_W;
            if (wr_en_i) begin
                cfg_d[i].trig = trig_e'(wr_data_i[base+BIT_TRIG +: 2]);
                cfg_d[i].en   = wr_data_i[base+BIT_EN];
                cfg_d[i].csel = wr_data_i[base+BIT_CSEL];
                clr[i]        = wr_data_i[base+BIT_PEND];
            end
            rd_data_o[base+BIT_TRIG +: 2] = cfg_q[i].trig;
            rd_data_o[base+BIT_EN]        = cfg_q[i].en;
            rd_data_o[base+BIT_CSEL]      = cfg_q[i].csel;
            rd_data_o[base+BIT_PEND]      = pend[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        extirq_line u_line (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sync_i (pin_sync[g]),
            .cfg_i  (cfg_q[g]),
            .clr_i  (clr[g]),
            .pend_o (pend[g]),
            .req_o  (req_o[g])
        );
    end
endmodule

// File: tb/tb_extirq_cond.sv
module tb_extirq_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  pins = '0;
    logic [2:0]  req;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    extirq_cond dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .pin_i(pins), .req_o(req)
    );

    function automatic logic [31:0] fld(int i, logic [1:0] trig, logic en,
                                        logic csel, logic clr);
        logic [7:0] f;
        f = {trig, en, csel, 3'b000, clr};
        return 32'(f) << ((2 - i) * 8);
    endfunction

    function automatic logic pend_of(int i);
        return rd_data[(2 - i) * 8];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] v);
        wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clean();
        pins = '0;
        wr(32'h0);
        idle(4);
    endtask

    task automatic t_reset();
        chk("R1 reset register", rd_data, 32'h0);
        chk("R1 reset requests", 32'(req), 32'h0);
    endtask

    task automatic t_layout();
        wr(32'hFFFF_FFFF);
        chk("R2 reserved bits and pending read zero", rd_data, 32'h00F0_F0F0);
        wr(fld(0, 2'b01, 1'b0, 1'b1, 1'b0) | fld(2, 2'b10, 1'b1, 1'b0, 1'b0));
        chk("R2 field positions", rd_data, 32'h0050_00A0);
        clean();
    endtask

    task automatic t_latency();
        wr(fld(1, 2'b00, 1'b1, 1'b0, 1'b0));
        idle(3);
        chk("R10 level high idle", 32'(req[1]), 32'h0);
        pins[1] = 1'b1;
        @(negedge clk);
        chk("R10 not after one edge", 32'(req[1]), 32'h0);
        @(negedge clk);
        chk("R10 after second edge", 32'(req[1]), 32'h1);
        chk("R1 other lines quiet", 32'({req[2], req[0]}), 32'h0);
        clean();
    endtask

    task automatic t_level_low();
        wr(fld(1, 2'b01, 1'b1, 1'b0, 1'b0));
        idle(3);
        chk("R3 level low pin low requests", 32'(req[1]), 32'h1);
        chk("R5 level pending reads zero", 32'(pend_of(1)), 32'h0);
        pins[1] = 1'b1;
        idle(3);
        chk("R3 level low pin high quiet", 32'(req[1]), 32'h0);
        clean();
    endtask

    task automatic t_rise();
        wr(fld(0, 2'b10, 1'b1, 1'b0, 1'b0));
        idle(2);
        pins[0] = 1'b1;
        idle(4);
        chk("R4 rising edge request", 32'(req[0]), 32'h1);
        chk("R4 rising edge pending", 32'(pend_of(0)), 32'h1);
        pins[0] = 1'b0;
        idle(4);
        chk("R4 pending sticky after pin drops", 32'(req[0]), 32'h1);
        wr(fld(0, 2'b10, 1'b1, 1'b0, 1'b0));
        idle(1);
        chk("R6 writing zero keeps pending", 32'(pend_of(0)), 32'h1);
        wr(fld(0, 2'b10, 1'b1, 1'b0, 1'b1));
        chk("R6 writing one clears", 32'(pend_of(0)), 32'h0);
        chk("R6 request drops on clear", 32'(req[0]), 32'h0);
        clean();
    endtask

    task automatic t_fall();
        wr(fld(2, 2'b11, 1'b1, 1'b0, 1'b0));
        idle(4);
        chk("R4 falling mode idle low pin", 32'(req[2]), 32'h0);
        pins[2] = 1'b1;
        idle(4);
        chk("R4 falling mode ignores rise", 32'(pend_of(2)), 32'h0);
        pins[2] = 1'b0;
        idle(4);
        chk("R4 falling edge request", 32'(req[2]), 32'h1);
        wr(fld(2, 2'b11, 1'b1, 1'b0, 1'b1));
        chk("R6 clear falling pending", 32'(req[2]), 32'h0);
        clean();
    endtask

    task automatic t_collide();
        wr(fld(0, 2'b10, 1'b1, 1'b0, 1'b0));
        idle(2);
        pins[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(fld(0, 2'b10, 1'b1, 1'b0, 1'b1));
        chk("R7 edge beats clear pending", 32'(pend_of(0)), 32'h1);
        chk("R7 edge beats clear request", 32'(req[0]), 32'h1);
        wr(fld(0, 2'b10, 1'b1, 1'b0, 1'b1));
        chk("R6 later clear works", 32'(pend_of(0)), 32'h0);
        clean();
    endtask

    task automatic t_mask();
        wr(fld(0, 2'b10, 1'b0, 1'b0, 1'b0));
        idle(2);
        pins[0] = 1'b1;
        idle(4);
        chk("R8 masked line quiet", 32'(req[0]), 32'h0);
        chk("R8 masked line still latches", 32'(pend_of(0)), 32'h1);
        wr(fld(0, 2'b10, 1'b1, 1'b0, 1'b0));
        chk("R8 unmask raises request", 32'(req[0]), 32'h1);
        wr(fld(1, 2'b00, 1'b0, 1'b0, 1'b0));
        pins[1] = 1'b1;
        idle(3);
        chk("R8 masked level line quiet", 32'(req[1]), 32'h0);
        clean();
    endtask

    task automatic t_csel();
        wr(fld(2, 2'b00, 1'b1, 1'b1, 1'b0));
        chk("R9 clock select read back", rd_data, 32'h0000_0030);
        idle(3);
        chk("R9 clock select no request", 32'(req[2]), 32'h0);
        pins[2] = 1'b1;
        idle(3);
        chk("R9 clock select level follows", 32'(req[2]), 32'h1);
        clean();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_layout();
        t_latency();
        t_level_low();
        t_rise();
        t_fall();
        t_collide();
        t_mask();
        t_csel();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule